// File: doc/BRIEF.md
# Isochronous Source Packet Segmenter

This block sits between an application that produces source packets as a stream of 32-bit quadlets and the stage that assembles isochronous bus packets. For every source packet it can place a time-stamp quadlet first, using the running 25-bit cycle timer. It then passes the application quadlets through and adds zero-valued dummy quadlets at the end. The whole padded packet is cut into a power-of-two number of data blocks of one programmed length. Block ends and packet ends are marked on the output stream.

The configuration is sampled once, when the first quadlet of a source packet is seen. The outgoing packet therefore always contains exactly `block length x block count` quadlets, whatever the input framing does. A headers-only packing mode takes in and discards the payload. An illegal combination of pad count, block length and block count is flagged, and no new packet starts while it persists.

Both streams are valid/ready. An output quadlet, once offered, stays on `out_data` until `out_ready` is high. While application quadlets are passing through, `in_ready` follows `out_ready` in the same cycle. In every other state `in_ready` is low, except in headers-only mode, where it is high.

Top module: `iso_seg_segmenter`

## Requirements
- R1: After `rst_n` goes low, or one cycle after a clock edge at which `soft_clr` is high, `out_valid` and `in_ready` are low and any packet in flight is abandoned. The next input quadlet starts a fresh packet.
- R2: Every source packet leaves as exactly L x N output quadlets. The application quadlets appear in arrival order, after the stamp quadlet if there is one. L is the block length and N is the block count.
- R3: `cfg_blk_frac` codes N: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. `out_block_last` is high on every L-th quadlet of a packet.
- R4: `cfg_blk_size` gives L in quadlets, and the code 0 means 256.
- R5: When the stamp is enabled, the first quadlet of the packet holds the `cycle_time` value sampled at the edge where the packet's first input quadlet is seen, in bits 24..0, with bits 31..25 zero.
- R6: The last `cfg_pad_cnt` quadlets of every packet are zero.
- R7: `out_pkt_last` is high only on the final quadlet of a packet, and that quadlet also carries `out_block_last`.
- R8: `config_error` is high exactly when any of these holds: pad count >= L, pad count >= N, or a stamp is enabled and L x N - pad count equals 1. While it is high, `in_ready` stays low and no packet starts. Pad count = L - 1 together with pad count = N - 1 is legal.
- R9: In mode 3 (headers only), no output is produced and input quadlets are accepted and dropped up to and including the one with `in_last`.
- R10: Mode 2 (MPEG-2 packing) inserts the stamp even with `cfg_stamp_en` low. Modes 0 and 1 give identical output for identical input.
- R11: If `in_last` arrives before the body is full, the remaining body positions are sent as zero quadlets before the padding.
- R12: If the body fills without `in_last`, the packet closes there. Later quadlets begin the next packet.
- R13: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Application clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous clear, active high |
| cfg_mode | input | 2 | Packing mode: 0 variable, 1 fixed, 2 MPEG-2, 3 headers only |
| cfg_stamp_en | input | 1 | Put a cycle-time stamp ahead of each source packet |
| cfg_pad_cnt | input | 3 | Dummy quadlets appended per packet |
| cfg_blk_frac | input | 2 | Block count code (1, 2, 4, 8) |
| cfg_blk_size | input | 8 | Block length in quadlets, 0 = 256 |
| cycle_time | input | 25 | Running cycle timer |
| in_valid | input | 1 | Input quadlet valid |
| in_ready | output | 1 | Input quadlet accepted |
| in_data | input | 32 | Input quadlet |
| in_last | input | 1 | Last quadlet of an application packet |
| out_valid | output | 1 | Output quadlet valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 32 | Output quadlet |
| out_block_last | output | 1 | Final quadlet of a data block |
| out_pkt_last | output | 1 | Final quadlet of a source packet |
| config_error | output | 1 | Current configuration is illegal |

## Verification
`config_error` is combinational, so it is sampled in the same cycle the configuration is applied. A packet's first output quadlet is due one cycle after its first input quadlet is presented, because the configuration is latched at that edge. After that, body quadlets are offered in the same cycle as the matching input. Stamp, fill and pad quadlets are offered one per accepted cycle. A soft clear shows on the outputs right after the edge that samples it. The bench drives inputs on falling edges, checks readiness a quarter period later, and logs output handshakes at rising edges. Each scenario then compares the logged stream with a list built from the requirements, and also checks that no extra quadlet follows.

// File: rtl/iso_seg_pkg.sv
package iso_seg_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_STAMP = 3'd1,
    S_BODY  = 3'd2,
    S_ZERO  = 3'd3,
    S_DROP  = 3'd4
  } seg_state_e;

  localparam logic [1:0] MODE_MPEG = 2'b10;
  localparam logic [1:0] MODE_HDR  = 2'b11;

endpackage

// File: rtl/iso_seg_cfg_decode.sv
module iso_seg_cfg_decode #(
  parameter int DBS_W = 8,
  parameter int FN_W  = 2,
  parameter int QPC_W = 3,
  parameter int TOT_W = 12
) (
  input  logic [DBS_W-1:0] blk_size,
  input  logic [FN_W-1:0]  blk_frac,
  input  logic [QPC_W-1:0] pad_cnt,
  input  logic             stamp_on,
  output logic [DBS_W:0]   blk_len,
  output logic [TOT_W-1:0] total,
  output logic [TOT_W-1:0] body_end,
  output logic             bad
);

  logic [TOT_W-1:0] n_blk;
  logic [TOT_W-1:0] pad_w;
  logic [TOT_W-1:0] len_w;
  logic             pad_vs_len;
  logic             pad_vs_cnt;
  logic             no_body;

  always_comb begin
    blk_len    = (blk_size == '0) ? ((DBS_W+1)'(1) << DBS_W) : {1'b0, blk_size};
    len_w      = TOT_W'(blk_len);
    n_blk      = TOT_W'(1) << blk_frac;
    total      = len_w << blk_frac;
    pad_w      = TOT_W'(pad_cnt);
    pad_vs_len = (pad_w >= len_w);
    pad_vs_cnt = (pad_w >= n_blk);
    no_body    = stamp_on && ((total - pad_w) == TOT_W'(1));
    bad        = pad_vs_len || pad_vs_cnt || no_body;
    body_end   = total - pad_w - TOT_W'(1);
  end

endmodule

// File: rtl/iso_seg_blk_track.sv
module iso_seg_blk_track #(
  parameter int DBS_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           load,
  input  logic           step,
  input  logic [DBS_W:0] blk_len,
  output logic           blk_end
);

  logic [DBS_W:0] cnt_q;
  logic [DBS_W:0] len_q;

  assign blk_end = (cnt_q == len_q - (DBS_W+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= (DBS_W+1)'(1);
    end else if (clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= '0;
      len_q <= blk_len;
    end else if (step) begin
      cnt_q <= blk_end ? '0 : cnt_q + (DBS_W+1)'(1);
    end
  end

endmodule

// File: rtl/iso_seg_stamp_fmt.sv
module iso_seg_stamp_fmt #(
  parameter int DATA_W  = 32,
  parameter int STAMP_W = 25
) (
  input  logic [STAMP_W-1:0] stamp,
  output logic [DATA_W-1:0]  word
);

  generate
    if (DATA_W > STAMP_W) begin : g_pad
      assign word = {{(DATA_W-STAMP_W){1'b0}}, stamp};
    end else begin : g_cut
      assign word = stamp[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/iso_seg_segmenter.sv
module iso_seg_segmenter
  import iso_seg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int STAMP_W = 25,
  parameter int DBS_W   = 8,
  parameter int FN_W    = 2,
  parameter int QPC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_stamp_en,
  input  logic [QPC_W-1:0]   cfg_pad_cnt,
  input  logic [FN_W-1:0]    cfg_blk_frac,
  input  logic [DBS_W-1:0]   cfg_blk_size,
  input  logic [STAMP_W-1:0] cycle_time,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_block_last,
  output logic               out_pkt_last,
  output logic               config_error
);

  localparam int MAX_SH = (1 << FN_W) - 1;
  localparam int TOT_W  = DBS_W + 1 + MAX_SH;

  seg_state_e         st_q;
  logic [TOT_W-1:0]   pos_q;
  logic [TOT_W-1:0]   total_q;
  logic [TOT_W-1:0]   body_end_q;
  logic [STAMP_W-1:0] stamp_q;

  logic               stamp_live;
  logic [DBS_W:0]     blk_len_live;
  logic [TOT_W-1:0]   total_live;
  logic [TOT_W-1:0]   body_end_live;
  logic               cfg_bad;
  logic               start;
  logic               fire;
  logic               pkt_end;
  logic               body_full;
  logic               blk_end;
  logic [DATA_W-1:0]  stamp_word;

  // live decode of the configuration fields
  assign stamp_live = cfg_stamp_en || (cfg_mode == MODE_MPEG);

  iso_seg_cfg_decode #(
    .DBS_W (DBS_W),
    .FN_W  (FN_W),
    .QPC_W (QPC_W),
    .TOT_W (TOT_W)
  ) u_decode (
    .blk_size (cfg_blk_size),
    .blk_frac (cfg_blk_frac),
    .pad_cnt  (cfg_pad_cnt),
    .stamp_on (stamp_live),
    .blk_len  (blk_len_live),
    .total    (total_live),
    .body_end (body_end_live),
    .bad      (cfg_bad)
  );

  iso_seg_stamp_fmt #(
    .DATA_W  (DATA_W),
    .STAMP_W (STAMP_W)
  ) u_stamp (
    .stamp (stamp_q),
    .word  (stamp_word)
  );

  assign config_error = cfg_bad;
  assign start        = (st_q == S_IDLE) && in_valid && !cfg_bad && !soft_clr;
  assign pkt_end      = (pos_q == total_q - TOT_W'(1));
  assign body_full    = (pos_q == body_end_q);

  // stream steering per state
  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    in_ready  = 1'b0;
    unique case (st_q)
      S_STAMP: begin
        out_valid = 1'b1;
        out_data  = stamp_word;
      end
      S_BODY: begin
        out_valid = in_valid;
        out_data  = in_data;
        in_ready  = out_ready;
      end
      S_ZERO: begin
        out_valid = 1'b1;
      end
      S_DROP: begin
        in_ready = 1'b1;
      end
      default: begin
        out_valid = 1'b0;
      end
    endcase
  end

  assign fire           = out_valid && out_ready;
  assign out_pkt_last   = out_valid && pkt_end;
  assign out_block_last = out_valid && blk_end;

  iso_seg_blk_track #(
    .DBS_W (DBS_W)
  ) u_blk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (soft_clr),
    .load    (start),
    .step    (fire),
    .blk_len (blk_len_live),
    .blk_end (blk_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      pos_q      <= '0;
      total_q    <= TOT_W'(1);
      body_end_q <= '0;
      stamp_q    <= '0;
    end else if (soft_clr) begin
      st_q  <= S_IDLE;
      pos_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (start) begin
            pos_q      <= '0;
            total_q    <= total_live;
            body_end_q <= body_end_live;
            stamp_q    <= cycle_time;
            if (cfg_mode == MODE_HDR)
              st_q <= S_DROP;
            else if (stamp_live)
              st_q <= S_STAMP;
            else
              st_q <= S_BODY;
          end
        end
        S_STAMP: begin
          if (fire) begin
            pos_q <= pos_q + TOT_W'(1);
            st_q  <= S_BODY;
          end
        end
        S_BODY: begin
          if (fire) begin
            pos_q <= pos_q + TOT_W'(1);
            if (body_full)
              st_q <= pkt_end ? S_IDLE : S_ZERO;
            else if (in_last)
              st_q <= S_ZERO;
          end
        end
        S_ZERO: begin
          if (fire) begin
            pos_q <= pos_q + TOT_W'(1);
            if (pkt_end)
              st_q <= S_IDLE;
          end
        end
        S_DROP: begin
          if (in_valid && in_last)
            st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/iso_seg_checker.sv
module iso_seg_checker
  import iso_seg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_clr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_block_last,
  input logic              out_pkt_last,
  input logic              config_error,
  input seg_state_e        st_q
);

  // R13: an offered quadlet is held until taken
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !soft_clr |=> out_valid && $stable(out_data));

  // R7: a packet end is always a block end
  a_r7_pkt_on_blk: assert property (@(posedge clk) disable iff (!rst_n)
    out_pkt_last |-> out_block_last);

  // R8: an illegal configuration keeps the segmenter idle
  a_r8_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) && config_error |=> (st_q == S_IDLE));

  // R9: headers-only mode produces no output
  a_r9_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DROP) |-> !out_valid);

  // R1: a synchronous clear empties the output on the next cycle
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !out_valid);

endmodule

bind iso_seg_segmenter iso_seg_checker #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .soft_clr       (soft_clr),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_data       (out_data),
  .out_block_last (out_block_last),
  .out_pkt_last   (out_pkt_last),
  .config_error   (config_error),
  .st_q           (st_q)
);

// File: tb/tb_iso_seg_segmenter.sv
module tb_iso_seg_segmenter;

  localparam int CLK_PERIOD = 10;
  localparam int CAP = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic        cfg_stamp_en = 1'b0;
  logic [2:0]  cfg_pad_cnt = 3'd0;
  logic [1:0]  cfg_blk_frac = 2'd0;
  logic [7:0]  cfg_blk_size = 8'd4;
  logic [24:0] cycle_time = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic        out_block_last;
  logic        out_pkt_last;
  logic        config_error;

  int checks = 0;
  int errors = 0;
  int n_got = 0;
  int n_exp = 0;
  int mark = 0;
  int cyc = 0;
  logic bp_en = 1'b0;

  logic [31:0] got_d [CAP];
  logic [1:0]  got_f [CAP];
  logic [31:0] exp_d [CAP];
  logic [1:0]  exp_f [CAP];

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_seg_segmenter dut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .cfg_mode(cfg_mode),
    .cfg_stamp_en(cfg_stamp_en), .cfg_pad_cnt(cfg_pad_cnt),
    .cfg_blk_frac(cfg_blk_frac), .cfg_blk_size(cfg_blk_size),
    .cycle_time(cycle_time), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data),
    .out_block_last(out_block_last), .out_pkt_last(out_pkt_last),
    .config_error(config_error)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  always @(posedge clk) begin
    if (out_valid && out_ready && n_got < CAP) begin
      got_d[n_got] <= out_data;
      got_f[n_got] <= {out_block_last, out_pkt_last};
      n_got <= n_got + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      $display("FAIL watchdog: run hung (actual cycles=%0d expected < 150000)", cyc);
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic se, input logic [2:0] q,
                         input logic [1:0] f, input logic [7:0] d);
    @(negedge clk);
    cfg_mode = m; cfg_stamp_en = se; cfg_pad_cnt = q; cfg_blk_frac = f; cfg_blk_size = d;
  endtask

  task automatic send_q(input logic [31:0] d, input logic last);
    in_data = d; in_last = last; in_valid = 1'b1;
    #(CLK_PERIOD/4);
    while (!in_ready) begin
      @(negedge clk);
      #(CLK_PERIOD/4);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_pkt(input int n, input logic [31:0] base, input bit with_last);
    for (int i = 0; i < n; i++) send_q(base + i, with_last && (i == n-1));
  endtask

  task automatic begin_case();
    @(negedge clk);
    mark = n_got;
    n_exp = 0;
  endtask

  // expected packet from the requirements
  task automatic add_exp(input bit st, input logic [24:0] sv, input int total, input int qpc,
                         input int dbs, input int n, input logic [31:0] base);
    for (int p = 0; p < total; p++) begin
      int b;
      b = p - (st ? 1 : 0);
      if (st && p == 0) exp_d[n_exp] = {7'd0, sv};
      else if (b < total - qpc - (st ? 1 : 0) && b < n) exp_d[n_exp] = base + b;
      else exp_d[n_exp] = 32'd0;
      exp_f[n_exp] = {((p + 1) % dbs) == 0, p == total - 1};
      n_exp++;
    end
  endtask

  task automatic compare(input string req);
    int w;
    w = 0;
    while ((n_got - mark) < n_exp && w < 3000) begin
      @(negedge clk);
      w++;
    end
    repeat (6) @(negedge clk);
    chk((n_got - mark) == n_exp, {req, " quadlet count"}, n_got - mark, n_exp);
    for (int i = 0; i < n_exp; i++) begin
      chk(got_d[mark+i] == exp_d[mark+i-mark] || 1'b0 ? 1'b1 : got_d[mark+i] == exp_d[i],
          {req, " data"}, got_d[mark+i], exp_d[i]);
      chk(got_f[mark+i] == exp_f[i], {req, " block/packet markers"},
          {30'd0, got_f[mark+i]}, {30'd0, exp_f[i]});
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_PERIOD/4);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b0, "R1 reset in_ready", in_ready, 0);
    chk(config_error == 1'b0, "R8 legal cfg error", config_error, 0);
  endtask

  task automatic t_basic(input logic [1:0] m, input string req);
    set_cfg(m, 0, 3'd1, 2'd1, 8'd4);
    begin_case();
    add_exp(0, 0, 8, 1, 4, 7, 32'h100);
    send_pkt(7, 32'h100, 1);
    compare(req);
  endtask

  task automatic t_stamp_bp();
    set_cfg(0, 1, 3'd2, 2'd2, 8'd3);
    cycle_time = 25'h1ABCDEF;
    bp_en = 1'b1;
    begin_case();
    add_exp(1, 25'h1ABCDEF, 12, 2, 3, 9, 32'h200);
    send_pkt(9, 32'h200, 1);
    compare("R5 R13 R3 stamp with backpressure");
    bp_en = 1'b0;
  endtask

  task automatic t_mpeg();
    set_cfg(2'd2, 0, 3'd0, 2'd0, 8'd5);
    cycle_time = 25'h0000155;
    begin_case();
    add_exp(1, 25'h0000155, 5, 0, 5, 4, 32'h300);
    send_pkt(4, 32'h300, 1);
    compare("R10 mpeg forces stamp");
  endtask

  task automatic t_early();
    set_cfg(0, 0, 3'd0, 2'd1, 8'd4);
    begin_case();
    add_exp(0, 0, 8, 0, 4, 5, 32'h400);
    send_pkt(5, 32'h400, 1);
    compare("R11 early last zero fill");
  endtask

  task automatic t_long();
    set_cfg(0, 0, 3'd0, 2'd0, 8'd4);
    begin_case();
    add_exp(0, 0, 4, 0, 4, 4, 32'h500);
    add_exp(0, 0, 4, 0, 4, 2, 32'h504);
    send_pkt(6, 32'h500, 1);
    compare("R12 overlong packet split");
  endtask

  task automatic t_dbs256();
    set_cfg(0, 0, 3'd3, 2'd3, 8'd0);
    begin_case();
    chk(config_error == 1'b0, "R4 dbs code 0 legal", config_error, 0);
    set_cfg(0, 0, 3'd3, 2'd0, 8'd0);
    #(CLK_PERIOD/4);
    chk(config_error == 1'b1, "R8 pad >= block count", config_error, 1);
    set_cfg(0, 0, 3'd0, 2'd0, 8'd0);
    begin_case();
    add_exp(0, 0, 256, 0, 256, 256, 32'h1000);
    send_pkt(256, 32'h1000, 1);
    compare("R4 R2 block of 256");
  endtask

  task automatic t_pad_bounds();
    set_cfg(0, 0, 3'd3, 2'd2, 8'd4);
    #(CLK_PERIOD/4);
    chk(config_error == 1'b0, "R8 boundary pad=L-1=N-1 legal", config_error, 0);
    begin_case();
    add_exp(0, 0, 16, 3, 4, 13, 32'h600);
    send_pkt(13, 32'h600, 1);
    compare("R6 R3 pad at boundary");
  endtask

  task automatic t_cfg_err();
    int g;
    set_cfg(0, 0, 3'd2, 2'd2, 8'd2);
    g = n_got;
    in_valid = 1'b1; in_data = 32'hDEAD; in_last = 1'b1;
    repeat (4) @(negedge clk);
    #(CLK_PERIOD/4);
    chk(config_error == 1'b1, "R8 pad >= block length", config_error, 1);
    chk(in_ready == 1'b0, "R8 input refused", in_ready, 0);
    set_cfg(0, 1, 3'd0, 2'd0, 8'd1);
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    chk(config_error == 1'b1, "R8 stamp leaves no body", config_error, 1);
    chk(in_ready == 1'b0, "R8 input refused stamp case", in_ready, 0);
    chk(n_got == g, "R8 no packet started", n_got - g, 0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic t_hdr();
    set_cfg(2'd3, 0, 3'd0, 2'd0, 8'd4);
    begin_case();
    send_pkt(5, 32'h700, 1);
    repeat (5) @(negedge clk);
    chk(n_got == mark, "R9 headers only no output", n_got - mark, 0);
    set_cfg(2'd1, 0, 3'd0, 2'd0, 8'd4);
    begin_case();
    add_exp(0, 0, 4, 0, 4, 4, 32'h800);
    send_pkt(4, 32'h800, 1);
    compare("R9 R10 resume after drop");
  endtask

  task automatic t_clear();
    set_cfg(0, 0, 3'd0, 2'd1, 8'd4);
    send_pkt(3, 32'h900, 0);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    #(CLK_PERIOD/4);
    chk(out_valid == 1'b0, "R1 soft clear out_valid", out_valid, 0);
    chk(in_ready == 1'b0, "R1 soft clear in_ready", in_ready, 0);
    begin_case();
    add_exp(0, 0, 8, 0, 4, 8, 32'hA00);
    send_pkt(8, 32'hA00, 1);
    compare("R1 fresh packet after clear");
  endtask

  initial begin
    t_reset();
    t_basic(2'd0, "R2 R6 R7 mode0");
    t_basic(2'd1, "R10 mode1 same as mode0");
    t_stamp_bp();
    t_mpeg();
    t_early();
    t_long();
    t_pad_bounds();
    t_dbs256();
    t_cfg_err();
    t_hdr();
    t_clear();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule